// File: doc/BRIEF.md
# Bus-Width Matching Adapter

This block sits on both edges of a 40-bit FIFO core and matches the core's word width to narrower external buses. On the write side it packs 20-bit or 10-bit input slices into full 40-bit words before they enter the core. On the read side it splits full 40-bit words from the core into 20-bit or 10-bit output slices. Each of the four edges (external input, packed word to the core, word from the core, external output) uses a valid/ready handshake.

The ratio is chosen by three configuration pins that are captured only while master reset is held low. The five legal codes select 40/40, 40-to-20, 40-to-10, 20-to-40 and 10-to-40. Any other code falls back to 40/40. Only one side converts in a given mode, so packing and unpacking never happen together. A partial reset empties the data path but keeps the captured ratio.

Top module: `bus_width_adapter`

## Requirements
- R1: The ratio is captured from {cfg_bm, cfg_iw, cfg_ow} on every clock edge while rst_n is low. Changes on those pins while rst_n is high have no effect.
- R2: Code 0,0,0 passes each 40-bit input word through unchanged as one packed word, and each 40-bit core word through unchanged as one output word.
- R3: Code 1,0,0 splits each core word into two 20-bit output slices. Bits 19:0 are sent first, then bits 39:20. out_data bits 39:20 are driven to zero.
- R4: Code 1,0,1 splits each core word into four 10-bit output slices, starting with bits 9:0 and going up. out_data bits 39:10 are driven to zero.
- R5: Code 1,1,0 packs two 20-bit input slices into one word. The first slice accepted lands in bits 19:0. in_data bits 39:20 are ignored.
- R6: Code 1,1,1 packs four 10-bit input slices into one word, the first at bits 9:0. in_data bits 39:10 are ignored.
- R7: The codes 0,0,1, 0,1,0 and 0,1,1 behave exactly like 0,0,0.
- R8: A low part_rst_n discards a partly packed word and any unsent slices and returns the slice counters to zero. The captured ratio is kept.
- R9: After master reset, in_ready and up_ready are 1, and pk_valid and out_valid are 0.
- R10: While pk_valid or out_valid is high and its ready is low, the valid stays high and the data stays unchanged.
- R11: pk_valid rises one clock after the last slice of a word is accepted. out_valid with the first slice follows one clock after a core word is accepted. Each later slice follows one clock after the previous slice is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, synchronous, active low; captures the ratio |
| part_rst_n | input | 1 | Partial reset, synchronous, active low; keeps the ratio |
| cfg_bm | input | 1 | Bus-match configuration bit |
| cfg_iw | input | 1 | Input-width configuration bit |
| cfg_ow | input | 1 | Output-width configuration bit |
| in_valid | input | 1 | External write slice valid |
| in_ready | output | 1 | External write slice accepted when high |
| in_data | input | 40 | External write slice, right-aligned |
| pk_valid | output | 1 | Packed word valid towards the core |
| pk_ready | input | 1 | Core accepts the packed word |
| pk_data | output | 40 | Packed word |
| up_valid | input | 1 | Core read word valid |
| up_ready | output | 1 | Adapter accepts the core word |
| up_data | input | 40 | Core read word |
| out_valid | output | 1 | External read slice valid |
| out_ready | input | 1 | External reader takes the slice |
| out_data | output | 40 | External read slice, right-aligned |

## Verification
Both converters place a single register between handshake and result. A packed word is therefore due one clock edge after its final slice is accepted, and a read slice is due one edge after the core word is accepted or after the previous slice is taken. The bench changes inputs on the falling edge and reads results on the next falling edge, half a period after the edge that produced them. Hold and backpressure checks read the same output again one full period later with ready held low.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    typedef enum logic [2:0] {
        MODE_40_40,
        MODE_40_20,
        MODE_40_10,
        MODE_20_40,
        MODE_10_40
    } bw_mode_e;

    // Three configuration bits to ratio; unknown codes fall back to 40/40.
    function automatic bw_mode_e decode_mode(input logic bm, input logic iw, input logic ow);
        case ({bm, iw, ow})
            3'b100:  return MODE_40_20;
            3'b101:  return MODE_40_10;
            3'b110:  return MODE_20_40;
            3'b111:  return MODE_10_40;
            default: return MODE_40_40;
        endcase
    endfunction

    // log2 of the number of slices on the write side.
    function automatic logic [1:0] wr_shift(input bw_mode_e m);
        case (m)
            MODE_20_40: return 2'd1;
            MODE_10_40: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    // log2 of the number of slices on the read side.
    function automatic logic [1:0] rd_shift(input bw_mode_e m);
        case (m)
            MODE_40_20: return 2'd1;
            MODE_40_10: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] last_slice(input logic [1:0] sh);
        case (sh)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/bwa_mode_reg.sv
module bwa_mode_reg
    import bwa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_bm,
    input  logic     cfg_iw,
    input  logic     cfg_ow,
    output bw_mode_e mode
);
    bw_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) begin
            mode_d = decode_mode(cfg_bm, cfg_iw, cfg_ow);
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R1: the captured ratio never moves outside master reset.
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/bwa_packer.sv
module bwa_packer
    import bwa_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              part_rst_n,
    input  logic [1:0]        shift,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              pk_valid,
    input  logic              pk_ready,
    output logic [WORD_W-1:0] pk_data
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [1:0]        cnt;
        logic              hold;
    } pk_state_t;

    pk_state_t   st_d, st_q;
    int unsigned slice_w;
    logic [1:0]  last;
    logic [WORD_W-1:0] mask, slice;
    logic        take, drain, ready_c;

    always_comb begin
        slice_w = WORD_W >> shift;
        last    = last_slice(shift);
        mask    = {WORD_W{1'b1}} >> (WORD_W - slice_w);
        slice   = (in_data & mask) << (int'(st_q.cnt) * slice_w);
        drain   = st_q.hold && pk_ready;
        ready_c = !st_q.hold || pk_ready;
        take    = in_valid && ready_c;

        st_d = st_q;
        if (drain) begin
            st_d.hold = 1'b0;
        end
        if (take) begin
            st_d.acc = (st_q.cnt == 2'd0) ? slice : (st_q.acc | slice);
            if (st_q.cnt == last) begin
                st_d.cnt  = 2'd0;
                st_d.hold = 1'b1;
            end else begin
                st_d.cnt = 2'(st_q.cnt + 2'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !part_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = ready_c;
    assign pk_valid = st_q.hold;
    assign pk_data  = st_q.acc;

    // R10: a packed word waits, unchanged, for the core.
    p_pk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
        pk_valid && !pk_ready |=> pk_valid && $stable(pk_data));

    // R11: the final slice of a word raises pk_valid on the next clock.
    p_pk_due_r11: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
        in_valid && in_ready && (st_q.cnt == last) |=> pk_valid);

endmodule

// File: rtl/bwa_unpacker.sv
module bwa_unpacker
    import bwa_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              part_rst_n,
    input  logic [1:0]        shift,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [WORD_W-1:0] up_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [1:0]        cnt;
        logic              have;
    } up_state_t;

    up_state_t   st_d, st_q;
    int unsigned slice_w;
    logic [1:0]  last;
    logic [WORD_W-1:0] mask;
    logic        give, done, ready_c, load;

    always_comb begin
        slice_w = WORD_W >> shift;
        last    = last_slice(shift);
        mask    = {WORD_W{1'b1}} >> (WORD_W - slice_w);
        give    = st_q.have && out_ready;
        done    = give && (st_q.cnt == last);
        ready_c = !st_q.have || done;
        load    = up_valid && ready_c;

        st_d = st_q;
        if (give) begin
            if (st_q.cnt == last) begin
                st_d.have = 1'b0;
                st_d.cnt  = 2'd0;
            end else begin
                st_d.cnt = 2'(st_q.cnt + 2'd1);
            end
        end
        if (load) begin
            st_d.word = up_data;
            st_d.have = 1'b1;
            st_d.cnt  = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !part_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_ready  = ready_c;
    assign out_valid = st_q.have;
    assign out_data  = (st_q.word >> (int'(st_q.cnt) * slice_w)) & mask;

    // R10: an offered slice stays put until taken.
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R11: taking a slice that is not the last keeps a slice on offer next clock.
    p_slice_next_r11: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
        out_valid && out_ready && (st_q.cnt != last) |=> out_valid);

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              part_rst_n,
    input  logic              cfg_bm,
    input  logic              cfg_iw,
    input  logic              cfg_ow,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              pk_valid,
    input  logic              pk_ready,
    output logic [WORD_W-1:0] pk_data,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [WORD_W-1:0] up_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    bw_mode_e   mode;
    logic [1:0] wsh, rsh;

    assign wsh = wr_shift(mode);
    assign rsh = rd_shift(mode);

    bwa_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_bm (cfg_bm),
        .cfg_iw (cfg_iw),
        .cfg_ow (cfg_ow),
        .mode   (mode)
    );

    bwa_packer #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .part_rst_n (part_rst_n),
        .shift      (wsh),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .pk_valid   (pk_valid),
        .pk_ready   (pk_ready),
        .pk_data    (pk_data)
    );

    bwa_unpacker #(.WORD_W(WORD_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .part_rst_n (part_rst_n),
        .shift      (rsh),
        .up_valid   (up_valid),
        .up_ready   (up_ready),
        .up_data    (up_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    // R2: a mode never converts on both sides at once.
    p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wsh == 2'd0) || (rsh == 2'd0));

    // R9: master reset leaves both output handshakes idle.
    p_idle_after_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !pk_valid && !out_valid);

endmodule

// File: tb/sim_bus_width_adapter.sv
module sim_bus_width_adapter;
    localparam int W = 40;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0, part_rst_n = 1'b1;
    logic cfg_bm = 1'b0, cfg_iw = 1'b0, cfg_ow = 1'b0;
    logic in_valid = 1'b0, pk_ready = 1'b0, up_valid = 1'b0, out_ready = 1'b0;
    logic [W-1:0] in_data = '0, up_data = '0;
    logic in_ready, pk_valid, up_ready, out_valid;
    logic [W-1:0] pk_data, out_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_width_adapter #(.WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n),
        .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_data(pk_data),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic bm, input logic iw, input logic ow);
        @(negedge clk);
        rst_n = 1'b0; cfg_bm = bm; cfg_iw = iw; cfg_ow = ow;
        in_valid = 1'b0; pk_ready = 1'b0; up_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_slice(input logic [W-1:0] d);
        in_valid = 1'b1; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_data = '0;
    endtask

    task automatic send_word_core(input logic [W-1:0] d);
        up_valid = 1'b1; up_data = d;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0; up_data = '0;
    endtask

    task automatic take_packed;
        pk_ready = 1'b1;
        @(negedge clk);
        pk_ready = 1'b0;
    endtask

    // Collect 2**sh slices, each due one clock after the previous is taken.
    task automatic expect_slices(input string req, input logic [W-1:0] w, input int sh);
        int wb = W >> sh;
        logic [W-1:0] m = (wb == W) ? {W{1'b1}} : ((40'h1 << wb) - 40'h1);
        for (int i = 0; i < (1 << sh); i++) begin
            chk({req, " slice valid"}, W'(out_valid), W'(1));
            chk({req, " slice data"}, out_data, (w >> (i * wb)) & m);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk({req, " drained"}, W'(out_valid), W'(0));
    endtask

    task automatic test_r9_reset_state;
        master_reset(1'b0, 1'b0, 1'b0);
        chk("R9 in_ready", W'(in_ready), W'(1));
        chk("R9 up_ready", W'(up_ready), W'(1));
        chk("R9 pk_valid", W'(pk_valid), W'(0));
        chk("R9 out_valid", W'(out_valid), W'(0));
    endtask

    task automatic test_r2_pass;
        master_reset(1'b0, 1'b0, 1'b0);
        send_slice(40'h13579BDF02);
        chk("R2 R11 pk_valid", W'(pk_valid), W'(1));
        chk("R2 pk_data", pk_data, 40'h13579BDF02);
        @(negedge clk);
        chk("R10 pk held", W'(pk_valid), W'(1));
        chk("R10 pk stable", pk_data, 40'h13579BDF02);
        take_packed();
        chk("R2 pk drained", W'(pk_valid), W'(0));
        send_word_core(40'hA5A5_5A5A_C3);
        expect_slices("R2", 40'hA5A5_5A5A_C3, 0);
    endtask

    task automatic test_r3_unpack20;
        master_reset(1'b1, 1'b0, 1'b0);
        send_word_core(40'h12345_6789A);
        @(negedge clk);
        chk("R10 out stable", out_data, 40'h00000_6789A);
        expect_slices("R3", 40'h12345_6789A, 1);
    endtask

    task automatic test_r4_unpack10_and_r1;
        master_reset(1'b1, 1'b0, 1'b1);
        cfg_bm = 1'b0; cfg_ow = 1'b0;   // R1: late pin change must not matter
        @(negedge clk);
        send_word_core(40'hFEDCBA9876);
        expect_slices("R4 R1", 40'hFEDCBA9876, 2);
    endtask

    task automatic test_r5_pack20;
        master_reset(1'b1, 1'b1, 1'b0);
        send_slice(40'hFFFFF_12345);
        chk("R5 no early word", W'(pk_valid), W'(0));
        send_slice(40'h0AAAA_6789A);
        chk("R5 R11 pk_valid", W'(pk_valid), W'(1));
        chk("R5 pk_data", pk_data, 40'h6789A_12345);
        take_packed();
    endtask

    task automatic test_r6_pack10;
        master_reset(1'b1, 1'b1, 1'b1);
        send_slice(40'hFF_FFFF_FD11);
        send_slice(40'h00_0000_0622);
        send_slice(40'h12_3456_7B33);
        chk("R6 no early word", W'(pk_valid), W'(0));
        send_slice(40'h80_0000_00AB);
        chk("R6 pk_valid", W'(pk_valid), W'(1));
        chk("R6 pk_data", pk_data, {10'h0AB, 10'h333, 10'h222, 10'h111});
        take_packed();
    endtask

    task automatic test_r7_unknown;
        master_reset(1'b0, 1'b1, 1'b1);
        send_slice(40'hC0FFEE1234);
        chk("R7 pk_data", pk_data, 40'hC0FFEE1234);
        take_packed();
        send_word_core(40'h0BADF00D77);
        expect_slices("R7", 40'h0BADF00D77, 0);
    endtask

    task automatic test_r8_partial;
        master_reset(1'b1, 1'b1, 1'b1);
        send_slice(40'h3FF);
        send_slice(40'h2AA);
        part_rst_n = 1'b0;
        @(negedge clk);
        part_rst_n = 1'b1;
        chk("R8 pk_valid", W'(pk_valid), W'(0));
        send_slice(40'h001);
        send_slice(40'h002);
        send_slice(40'h003);
        chk("R8 still 10-bit", W'(pk_valid), W'(0));
        send_slice(40'h004);
        chk("R8 pk_data", pk_data, {10'h004, 10'h003, 10'h002, 10'h001});
        take_packed();
    endtask

    initial begin
        test_r9_reset_state();
        test_r2_pass();
        test_r3_unpack20();
        test_r4_unpack10_and_r1();
        test_r5_pack20();
        test_r6_pack10();
        test_r7_unknown();
        test_r8_partial();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule